// File: doc/BRIEF.md
# Keyed Slow Clock Source Selector

This block chooses where the slow timekeeping clock of a chip comes from. One source is a fast internal RC oscillator slowed down by a programmable divider. The other is an external 32 kHz crystal, passed through without division. Software controls the choice through three 32-bit registers on a plain read/write bus.

The source-select register is protected. A write changes it only when the upper half of the written word holds the unlock key 0x16AA. A separate gate register drives a second output, which carries a copy of the selected clock to a pad.

When the source changes, the old clock leg is turned off before the new one is turned on. A request/acknowledge handshake runs between the bus domain and the two clock domains, so no runt pulse reaches the output. A state machine in the bus clock domain runs this handshake. It has six states:

- `SW_INT`: steady on the internal source. It moves to `SW_INT_OFF` when the select bit becomes 1.
- `SW_INT_OFF`: the internal request is dropped. It moves to `SW_EXT_ON` once the internal enable reads back as 0.
- `SW_EXT_ON`: the external request is raised. It moves to `SW_EXT` once the external enable reads back as 1.
- `SW_EXT`: steady on the external source. It moves to `SW_EXT_OFF` when the select bit becomes 0.
- `SW_EXT_OFF`: the external request is dropped. It moves to `SW_INT_ON` once the external enable reads back as 0.
- `SW_INT_ON`: the internal request is raised. It moves to `SW_INT` once the internal enable reads back as 1. Reset enters this state.

Top module: `lsc_clk_select`

## Requirements
- R1: A write to offset 0x00 whose bits 31:16 equal 0x16AA stores bit 0 as the source select (1 = external crystal, 0 = internal divided oscillator).
- R2: A write to offset 0x00 with any other value in bits 31:16 leaves the source select and the output clock unchanged.
- R3: A read of offset 0x00 returns the source select in bit 0 and zero in bits 31:1; the key is never stored.
- R4: Offset 0x08 holds a 5-bit divide field in bits 4:0, read back with zeros above it. With the internal source selected, the output period is (field + 1) internal oscillator periods.
- R5: With the external source selected, the output period equals the crystal period whatever the divide field holds.
- R6: Bit 0 of offset 0x60 enables the gated output. When it is 1, the gated output carries the selected clock; when it is 0, the gated output stays low. The bit reads back at bit 0.
- R7: During a source switch, no high or low pulse on the selected-clock output is shorter than half the internal oscillator period, and the two source enables are never on together.
- R8: After reset, the internal source is selected, the divide field is 0 and the gate is off.
- R9: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one bus cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rc_clk | input | 1 | Internal fast RC oscillator |
| xtal_clk | input | 1 | External crystal clock |
| clk_sel | output | 1 | Selected slow clock |
| clk_gated | output | 1 | Gated copy of clk_sel |

## Verification
The bench measures the period of the selected-clock output after random writes to the select and divide registers. It compares each result with the period that follows from the requirements, and it includes divide fields 0 and 31. A divider that is off by one, or that ignores the bypass, would show the wrong period. Writes with a near-miss key, such as one that differs only in its low byte, check that a partial key compare cannot slip a select change through. While switches are in progress, an edge monitor records every pulse width on the output, so a mux that enables the new leg before the old one falls silent shows up as a runt pulse. Writes to unmapped offsets and toggles of the gate bit show whether a register is clobbered and whether the gated output leaks while it is disabled.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 5;
    localparam int KEY_W  = 16;
    localparam logic [KEY_W-1:0]  UNLOCK_KEY = 16'h16AA;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PRE  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_GATE = 8'h60;

    typedef enum logic [2:0] {
        SW_INT     = 3'd0,
        SW_INT_OFF = 3'd1,
        SW_EXT_ON  = 3'd2,
        SW_EXT     = 3'd3,
        SW_EXT_OFF = 3'd4,
        SW_INT_ON  = 3'd5
    } sw_state_t;
endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              src_sel,
    output logic [PRE_W-1:0]  prescale,
    output logic              gate_en
);
    localparam int KEY_LO = DATA_W - KEY_W;

    logic wr_ctrl, wr_pre, wr_gate;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == OFF_CTRL)
                  && (bus_wdata[DATA_W-1:KEY_LO] == UNLOCK_KEY);
        wr_pre  = bus_wr && (bus_addr == OFF_PRE);
        wr_gate = bus_wr && (bus_addr == OFF_GATE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel  <= 1'b0;
            prescale <= '0;
            gate_en  <= 1'b0;
        end else begin
            if (wr_ctrl) src_sel  <= bus_wdata[0];
            if (wr_pre)  prescale <= bus_wdata[PRE_W-1:0];
            if (wr_gate) gate_en  <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL: bus_rdata[0] = src_sel;
            OFF_PRE:  bus_rdata[PRE_W-1:0] = prescale;
            OFF_GATE: bus_rdata[0] = gate_en;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lsc_divider.sv
module lsc_divider
    import lsc_pkg::*;
(
    input  logic             rc_clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    output logic             div_clk
);
    logic [PRE_W-1:0] cnt_q;
    logic             ce_q;

    always_ff @(posedge rc_clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (cnt_q >= prescale) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    // enable changes only while rc_clk is low, so the AND below never slices a pulse
    always_ff @(negedge rc_clk or negedge rst_n) begin
        if (!rst_n) ce_q <= 1'b0;
        else        ce_q <= (cnt_q == '0);
    end

    assign div_clk = rc_clk & ce_q;
endmodule

// File: rtl/lsc_switch.sv
module lsc_switch
    import lsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic div_clk,
    input  logic rc_clk,
    input  logic xtal_clk,
    output logic int_en,
    output logic ext_en,
    output logic clk_out
);
    sw_state_t state_q, state_d;
    logic req_int, req_ext;
    logic int_s1, ext_s1;
    logic [1:0] int_ack_q, ext_ack_q;
    logic int_ack, ext_ack;

    // request into the internal domain, two flops on the falling edge
    always_ff @(negedge rc_clk or negedge rst_n) begin
        if (!rst_n) begin
            int_s1 <= 1'b0;
            int_en <= 1'b0;
        end else begin
            int_s1 <= req_int;
            int_en <= int_s1;
        end
    end

    always_ff @(negedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_s1 <= 1'b0;
            ext_en <= 1'b0;
        end else begin
            ext_s1 <= req_ext;
            ext_en <= ext_s1;
        end
    end

    // acknowledges back into the bus domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_ack_q <= '0;
            ext_ack_q <= '0;
        end else begin
            int_ack_q <= {int_ack_q[0], int_en};
            ext_ack_q <= {ext_ack_q[0], ext_en};
        end
    end
    assign int_ack = int_ack_q[1];
    assign ext_ack = ext_ack_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_INT_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_INT:     if (src_sel)  state_d = SW_INT_OFF;
            SW_INT_OFF: if (!int_ack) state_d = SW_EXT_ON;
            SW_EXT_ON:  if (ext_ack)  state_d = SW_EXT;
            SW_EXT:     if (!src_sel) state_d = SW_EXT_OFF;
            SW_EXT_OFF: if (!ext_ack) state_d = SW_INT_ON;
            SW_INT_ON:  if (int_ack)  state_d = SW_INT;
            default:                  state_d = SW_INT_ON;
        endcase
    end

    always_comb begin
        req_int = (state_q == SW_INT) || (state_q == SW_INT_ON);
        req_ext = (state_q == SW_EXT) || (state_q == SW_EXT_ON);
    end

    assign clk_out = (div_clk & int_en) | (xtal_clk & ext_en);
endmodule

// File: rtl/lsc_clk_select.sv
module lsc_clk_select
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rc_clk,
    input  logic              xtal_clk,
    output logic              clk_sel,
    output logic              clk_gated
);
    logic             src_sel;
    logic [PRE_W-1:0] prescale;
    logic             gate_en;
    logic             div_clk;
    logic             int_en, ext_en;

    lsc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_sel   (src_sel),
        .prescale  (prescale),
        .gate_en   (gate_en)
    );

    lsc_divider u_div (
        .rc_clk   (rc_clk),
        .rst_n    (rst_n),
        .prescale (prescale),
        .div_clk  (div_clk)
    );

    lsc_switch u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .div_clk  (div_clk),
        .rc_clk   (rc_clk),
        .xtal_clk (xtal_clk),
        .int_en   (int_en),
        .ext_en   (ext_en),
        .clk_out  (clk_sel)
    );

    assign clk_gated = clk_sel & gate_en;
endmodule

// File: rtl/lsc_clk_select_chk.sv
module lsc_clk_select_chk
    import lsc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              src_sel,
    input logic [PRE_W-1:0]  prescale,
    input logic              int_en,
    input logic              ext_en
);
    localparam int KEY_LO = DATA_W - KEY_W;

    p_key_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTRL && bus_wdata[DATA_W-1:KEY_LO] == UNLOCK_KEY)
        |=> (src_sel == $past(bus_wdata[0])));

    p_key_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTRL && bus_wdata[DATA_W-1:KEY_LO] != UNLOCK_KEY)
        |=> $stable(src_sel));

    p_ctrl_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CTRL) |-> (bus_rdata[DATA_W-1:1] == '0));

    p_pre_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_PRE) |=> (prescale == $past(bus_wdata[PRE_W-1:0])));

    p_one_leg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_en && ext_en));
endmodule

bind lsc_clk_select lsc_clk_select_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_sel   (src_sel),
    .prescale  (prescale),
    .int_en    (int_en),
    .ext_en    (ext_en)
);

// File: tb/lsc_clk_select_bench.sv
`timescale 1ns/1ps
module lsc_clk_select_bench;
    localparam real RC_HALF = 3.0;
    localparam real XT_HALF = 17.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rc_clk = 1'b0;
    logic        xtal_clk = 1'b0;
    logic        clk_sel;
    logic        clk_gated;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  gated_edges = 0;
    int  runts = 0;
    bit  mon_on = 1'b0;
    real last_t = 0.0;

    always #5 clk = ~clk;
    always #(RC_HALF) rc_clk = ~rc_clk;
    always #(XT_HALF) xtal_clk = ~xtal_clk;

    lsc_clk_select u_lsc_clk_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rc_clk    (rc_clk),
        .xtal_clk  (xtal_clk),
        .clk_sel   (clk_sel),
        .clk_gated (clk_gated)
    );

    always @(posedge clk_gated) gated_edges++;

    // R7 pulse-width monitor
    always @(clk_sel) begin
        if (mon_on && ($realtime - last_t) < (RC_HALF - 0.1)) runts++;
        last_t = $realtime;
    end

    function automatic real exp_period(input bit sel, input int pre);
        return sel ? (2.0 * XT_HALF) : (2.0 * RC_HALF * (pre + 1));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (120) @(posedge clk);
    endtask

    task automatic check_period(input string req, input bit sel, input int pre);
        real t0, p;
        @(posedge clk_sel); @(posedge clk_sel);
        t0 = $realtime;
        @(posedge clk_sel);
        p = $realtime - t0;
        n_checks++;
        if (p < exp_period(sel, pre) - 0.01 || p > exp_period(sel, pre) + 0.01) begin
            n_fails++;
            $display("FAIL %s: period actual %0.3f expected %0.3f", req, p, exp_period(sel, pre));
        end
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit sel_m;
        int pre_m;
        int e0;
        void'($urandom(32'd4711));

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();

        // R8 reset state
        rd(8'h00, d); check("R8 ctrl", d, 0);
        rd(8'h08, d); check("R8 pre", d, 0);
        rd(8'h60, d); check("R8 gate", d, 0);
        check_period("R8 period", 1'b0, 0);
        sel_m = 1'b0; pre_m = 0;
        mon_on = 1'b1;

        // R6 gate off: no edges
        e0 = gated_edges;
        repeat (30) @(posedge clk);
        check("R6 gate off", gated_edges - e0, 0);
        wr(8'h60, 32'h1);
        rd(8'h60, d); check("R6 gate rd", d, 1);
        e0 = gated_edges;
        repeat (30) @(posedge clk);
        check("R6 gate on", (gated_edges - e0) > 0, 1);
        wr(8'h60, 32'h0);
        repeat (2) @(posedge clk);
        e0 = gated_edges;
        repeat (30) @(posedge clk);
        check("R6 gate reoff", gated_edges - e0, 0);

        // directed: divide field extremes
        wr(8'h08, 32'hFFFF_FFFF); pre_m = 31;
        rd(8'h08, d); check("R4 pre rd", d, 32'h1F);
        settle(); check_period("R4 pre31", 1'b0, 31);

        // R5 external with large divide field
        wr(8'h00, 32'h16AA_0001); sel_m = 1'b1;
        rd(8'h00, d); check("R1 ctrl rd", d, 1);
        settle(); check_period("R5 ext", 1'b1, pre_m);

        // R2 near-miss key
        wr(8'h00, 32'h16AB_0000);
        rd(8'h00, d); check("R2 near key", d, 1);
        settle(); check_period("R2 period", 1'b1, pre_m);
        wr(8'h00, 32'h06AA_0000);
        rd(8'h00, d); check("R2 hi nibble", d, 1);

        // R9 unmapped
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R9 rd 04", d, 0);
        rd(8'h08, d); check("R9 pre kept", d, 32'h1F);
        rd(8'h60, d); check("R9 gate kept", d, 0);
        rd(8'h00, d); check("R9 ctrl kept", d, 1);

        // R3 key never stored
        wr(8'h00, 32'h16AA_FFFE); sel_m = 1'b0;
        rd(8'h00, d); check("R3 ctrl rd", d, 0);
        wr(8'h08, 32'h0); pre_m = 0;
        settle(); check_period("R4 pre0", 1'b0, 0);

        // random mix
        for (int i = 0; i < 12; i++) begin
            int p;
            bit s, good;
            logic [15:0] k;
            p = $urandom_range(0, 31);
            s = $urandom_range(0, 1);
            good = $urandom_range(0, 3) != 0;
            k = good ? 16'h16AA : 16'(($urandom_range(1, 16'hFFFE) + 16'h16AA));
            wr(8'h08, {$urandom} & 32'hFFFF_FFE0 | 32'(p)); pre_m = p;
            wr(8'h00, {k, 15'h0, s});
            if (good) sel_m = s;
            rd(8'h00, d); check(good ? "R1 rand" : "R2 rand", d, {31'h0, sel_m});
            settle();
            check_period(sel_m ? "R5 rand" : "R4 rand", sel_m, pre_m);
        end

        check("R7 runts", runts, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule